// File: doc/BRIEF.md
# Buffered Serial Transmitter with Clear-to-Send Gating

This block sends asynchronous serial frames on a single output line. The bus side writes a data word into a holding buffer. The word moves into a frame shift register as soon as the shifter is free, so the bus can queue the next word while the current frame is still on the line. The bit rate comes from a divider that counts pulses of a count-source enable input. One bit lasts `OVS*(n+1)` of those pulses, where `n` is the programmed divider value and `OVS` defaults to 16. The design runs in one clock domain.

The frame format is set by control inputs and latched when a word enters the shifter. A frame carries 8 or 9 data bits, an optional even or odd parity bit, and one or two stop bits. An optional active-low clear-to-send input decides whether a new frame may begin. A high level stops transmission after the current frame, and a low level with data waiting starts a frame in the next cycle. The block reports buffer-empty and transmitter-empty status. It holds a latched interrupt request whose source is either the buffer handing its word to the shifter or the line going quiet after the last frame.

Top module: `utx_top`

## Requirements
- R1: `txd` is high whenever the shifter holds no frame, including while `tx_en` is 0.
- R2: Every bit of a frame lasts exactly `OVS*(div_n+1)` clock cycles in which `src_en` is 1.
- R3: A frame begins with a low start bit on `txd` one cycle after the word enters the shifter. The data bits follow, bit 0 first. There are 8 of them, or 9 (including `wr_data[8]`) when `data_nine` is 1.
- R4: When `par_en` is 1, one parity bit follows the data. Its value is the XOR of the sent data bits, inverted when `par_odd` is 1.
- R5: The frame ends with one high stop bit, or two when `stop_two` is 1.
- R6: A word written with `wr_en` enters the shifter when the shifter is idle, or at the end of the last stop bit with no idle gap. A write replaces any word still in the buffer.
- R7: `buf_empty` goes low the cycle after a write and goes high the cycle after the word enters the shifter.
- R8: `tx_empty` is high exactly when the buffer is empty and the shifter is idle.
- R9: With `cts_en` 1 and `cts_n` 1, no frame begins, even with a word buffered. The line stays high after the current frame completes.
- R10: With `cts_en` 1 and a word pending on an idle line, the start bit appears one cycle after `cts_n` is sampled low.
- R11: When `tx_en` is 0, a frame already on the line completes but no new frame begins. A buffered word stays in the buffer.
- R12: `irq_sel` 0 sets `irq_req` when a word enters the shifter. `irq_sel` 1 sets it when a frame ends with no following frame.
- R13: `irq_req` stays high until `irq_clr` is 1 in a cycle with no new event. A new event in the same cycle keeps it high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_en | input | 1 | Count-source pulse for the bit-rate divider |
| tx_en | input | 1 | Transmit enable |
| div_n | input | DIV_W | Divider value n |
| data_nine | input | 1 | 1: 9 data bits, 0: 8 data bits |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| stop_two | input | 1 | 1: two stop bits |
| cts_en | input | 1 | Clear-to-send gating enabled |
| cts_n | input | 1 | Clear-to-send, active low |
| irq_sel | input | 1 | Interrupt source: 0 word taken, 1 transmission complete |
| wr_en | input | 1 | Write strobe into the holding buffer |
| wr_data | input | 9 | Data word to send |
| irq_clr | input | 1 | Clears the interrupt request |
| txd | output | 1 | Serial data line |
| buf_empty | output | 1 | Holding buffer empty |
| tx_empty | output | 1 | Buffer and shifter both empty |
| irq_req | output | 1 | Latched interrupt request |

## Verification
The assertions assume that `cts_n` is already synchronous to `clk`. They also assume that `div_n` does not change while a frame is on the line, because the bit-period check counts against the divider value currently applied. The stimulus changes `cts_n` only on the falling clock edge. It reprograms the divider and the frame format only after `tx_empty` shows the line idle. It uses both a continuous and a sparse `src_en` pattern so that the period check sees pauses in the count source.

// File: rtl/utx_pkg.sv
package utx_pkg;

  localparam int unsigned DATA_W  = 9;
  localparam int unsigned FRAME_W = 1 + DATA_W + 1 + 2;
  localparam int unsigned LEN_W   = $clog2(FRAME_W + 1);

  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [LEN_W-1:0]   flen_t;

  typedef struct packed {
    logic nine;
    logic par;
    logic odd;
    logic two;
  } fmt_t;

  function automatic int unsigned bit_cycles(int unsigned ovs, int unsigned n);
    return ovs * (n + 1);
  endfunction

  function automatic logic parity_of(logic [DATA_W-1:0] d, fmt_t f);
    logic p;
    p = ^d[7:0];
    if (f.nine) p = p ^ d[8];
    return p ^ f.odd;
  endfunction

  function automatic flen_t frame_len(fmt_t f);
    int unsigned l;
    l = 1 + (f.nine ? 9 : 8) + (f.par ? 1 : 0) + (f.two ? 2 : 1);
    return flen_t'(l);
  endfunction

  function automatic frame_t build_frame(logic [DATA_W-1:0] d, fmt_t f);
    frame_t fr;
    int unsigned pos;
    fr     = '1;
    fr[0]  = 1'b0;
    pos    = 1;
    for (int i = 0; i < int'(DATA_W); i++) begin
      if (i < 8 || f.nine) begin
        fr[pos] = d[i];
        pos     = pos + 1;
      end
    end
    if (f.par) fr[pos] = parity_of(d, f);
    return fr;
  endfunction

endpackage

// File: rtl/utx_baud.sv
module utx_baud #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             src_en,
  input  logic [DIV_W-1:0] div_n,
  output logic             bit_tick
);
  import utx_pkg::*;

  localparam int unsigned CNT_W = $clog2(OVS * (2 ** DIV_W));

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             at_last;

  always_comb begin
    last    = CNT_W'(bit_cycles(OVS, int'(div_n)) - 1);
    at_last = (cnt == last);
  end

  assign bit_tick = run && src_en && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || restart) begin
      cnt <= '0;
    end else if (src_en) begin
      cnt <= at_last ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/utx_holdbuf.sv
module utx_holdbuf #(
  parameter int unsigned DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (wr_en) begin
        full <= 1'b1;
        data <= wr_data;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  utx_pkg::frame_t frame_in,
  input  utx_pkg::flen_t  len_in,
  input  logic            bit_tick,
  output logic            busy,
  output logic            frame_end,
  output logic            line
);
  import utx_pkg::*;

  frame_t sh;
  flen_t  remain;

  assign busy      = (remain != '0);
  assign frame_end = bit_tick && (remain == flen_t'(1));
  assign line      = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '1;
      remain <= '0;
    end else if (load) begin
      sh     <= frame_in;
      remain <= len_in;
    end else if (bit_tick && busy) begin
      sh     <= {1'b1, sh[FRAME_W-1:1]};
      remain <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/utx_top.sv
module utx_top #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_en,
  input  logic             tx_en,
  input  logic [DIV_W-1:0] div_n,
  input  logic             data_nine,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             stop_two,
  input  logic             cts_en,
  input  logic             cts_n,
  input  logic             irq_sel,
  input  logic             wr_en,
  input  logic [8:0]       wr_data,
  input  logic             irq_clr,
  output logic             txd,
  output logic             buf_empty,
  output logic             tx_empty,
  output logic             irq_req
);
  import utx_pkg::*;

  logic             buf_full;
  logic [DATA_W-1:0] buf_data;
  logic             busy;
  logic             frame_end;
  logic             bit_tick;
  logic             cts_ok;
  logic             can_start;
  logic             load_evt;
  logic             done_evt;
  logic             irq_set;
  fmt_t             fmt;
  frame_t           next_frame;
  flen_t            next_len;

  always_comb begin
    fmt.nine   = data_nine;
    fmt.par    = par_en;
    fmt.odd    = par_odd;
    fmt.two    = stop_two;
    next_frame = build_frame(buf_data, fmt);
    next_len   = frame_len(fmt);
  end

  assign cts_ok    = !cts_en || !cts_n;
  assign can_start = buf_full && tx_en && cts_ok;
  assign load_evt  = can_start && (!busy || frame_end);
  assign done_evt  = frame_end && !load_evt;
  assign irq_set   = irq_sel ? done_evt : load_evt;

  utx_holdbuf #(.DW(DATA_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (load_evt),
    .full    (buf_full),
    .data    (buf_data)
  );

  utx_baud #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .restart  (load_evt),
    .src_en   (src_en),
    .div_n    (div_n),
    .bit_tick (bit_tick)
  );

  utx_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_evt),
    .frame_in  (next_frame),
    .len_in    (next_len),
    .bit_tick  (bit_tick),
    .busy      (busy),
    .frame_end (frame_end),
    .line      (txd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
    end else begin
      irq_req <= irq_set || (irq_req && !irq_clr);
    end
  end

  assign buf_empty = !buf_full;
  assign tx_empty  = !buf_full && !busy;

endmodule

// File: rtl/utx_top_chk.sv
module utx_top_chk #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned OVS   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             src_en,
  input logic             tx_en,
  input logic [DIV_W-1:0] div_n,
  input logic             cts_en,
  input logic             cts_n,
  input logic             irq_sel,
  input logic             irq_clr,
  input logic             wr_en,
  input logic             txd,
  input logic             buf_empty,
  input logic             tx_empty,
  input logic             irq_req,
  input logic             busy,
  input logic             bit_tick,
  input logic             frame_end,
  input logic             load_evt,
  input logic             done_evt
);

  int unsigned pulses;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulses <= 0;
    end else if (load_evt || bit_tick) begin
      pulses <= 0;
    end else if (busy && src_en) begin
      pulses <= pulses + 1;
    end
  end

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R1

  AST_BIT_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (pulses == OVS * (int'(div_n) + 1) - 1)); // R2

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !txd); // R3

  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> txd); // R5

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !buf_empty); // R7

  AST_EMPTY_IMPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (buf_empty && !busy)); // R8

  AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && cts_en) |-> !cts_n); // R9

  AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> tx_en); // R11

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(irq_sel ? done_evt : load_evt)); // R12

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_clr) |=> irq_req); // R13

endmodule

bind utx_top utx_top_chk #(.DIV_W(DIV_W), .OVS(OVS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_en    (src_en),
  .tx_en     (tx_en),
  .div_n     (div_n),
  .cts_en    (cts_en),
  .cts_n     (cts_n),
  .irq_sel   (irq_sel),
  .irq_clr   (irq_clr),
  .wr_en     (wr_en),
  .txd       (txd),
  .buf_empty (buf_empty),
  .tx_empty  (tx_empty),
  .irq_req   (irq_req),
  .busy      (busy),
  .bit_tick  (bit_tick),
  .frame_end (frame_end),
  .load_evt  (load_evt),
  .done_evt  (done_evt)
);

// File: tb/sim_utx_top.sv
module sim_utx_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_en = 1'b1;
  logic       tx_en = 1'b0;
  logic [7:0] div_n = 8'd0;
  logic       data_nine = 1'b0;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       stop_two = 1'b0;
  logic       cts_en = 1'b0;
  logic       cts_n = 1'b0;
  logic       irq_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = 9'd0;
  logic       irq_clr = 1'b0;
  logic       txd, buf_empty, tx_empty, irq_req;

  int total = 0;
  int bad = 0;
  int src_mode = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  utx_top u0 (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .tx_en(tx_en), .div_n(div_n),
    .data_nine(data_nine), .par_en(par_en), .par_odd(par_odd),
    .stop_two(stop_two), .cts_en(cts_en), .cts_n(cts_n), .irq_sel(irq_sel),
    .wr_en(wr_en), .wr_data(wr_data), .irq_clr(irq_clr), .txd(txd),
    .buf_empty(buf_empty), .tx_empty(tx_empty), .irq_req(irq_req)
  );

  // reference model state
  bit     m_full = 0;
  bit [8:0] m_data = 0;
  bit     m_busy = 0;
  bit     m_q[$];
  int     m_cnt = 0;
  bit     m_irq = 0;

  always @(posedge clk) begin
    bit tick, fend, cstart, ld, fin, setv;
    if (!rst_n) begin
      m_full = 0; m_busy = 0; m_q.delete(); m_cnt = 0; m_irq = 0;
    end else begin
      tick   = m_busy && src_en && (m_cnt == 16 * (int'(div_n) + 1) - 1);
      fend   = tick && (m_q.size() == 1);
      cstart = m_full && tx_en && (!cts_en || !cts_n);
      ld     = cstart && (!m_busy || fend);
      fin    = fend && !ld;
      if (!m_busy || ld) m_cnt = 0;
      else if (src_en) m_cnt = tick ? 0 : m_cnt + 1;
      if (ld) begin
        int nb; bit p;
        nb = data_nine ? 9 : 8;
        p = par_odd;
        m_q.delete();
        m_q.push_back(1'b0);
        for (int i = 0; i < nb; i++) begin
          m_q.push_back(m_data[i]);
          p = p ^ m_data[i];
        end
        if (par_en) m_q.push_back(p);
        m_q.push_back(1'b1);
        if (stop_two) m_q.push_back(1'b1);
        m_busy = 1;
      end else if (tick) begin
        void'(m_q.pop_front());
        if (fin) m_busy = 0;
      end
      if (wr_en) begin m_full = 1; m_data = wr_data; end
      else if (ld) m_full = 0;
      setv  = irq_sel ? fin : ld;
      m_irq = setv || (m_irq && !irq_clr);
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    case (src_mode)
      0: src_en <= 1'b1;
      default: src_en <= (cyc % 3 == 0);
    endcase
    if (rst_n && !done) begin
      check("R1 R2 R3 R4 R5 R6 txd", txd, m_busy ? m_q[0] : 1'b1);
      check("R7 buf_empty", buf_empty, !m_full);
      check("R8 tx_empty", tx_empty, !m_busy && !m_full);
      check("R12 R13 irq_req", irq_req, m_irq);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write(input logic [8:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      if (tx_empty) break;
      @(negedge clk);
    end
    step(2);
  endtask

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // reset state: R1 R7 R8 R12
    check("R1 reset txd", txd, 1'b1);
    check("R7 reset buf_empty", buf_empty, 1'b1);
    check("R8 reset tx_empty", tx_empty, 1'b1);
    check("R12 reset irq", irq_req, 1'b0);

    // 8 data, no parity, one stop, n=0
    tx_en = 1'b1;
    @(negedge clk); wr_en = 1'b1; wr_data = 9'h0A5;
    @(negedge clk); wr_en = 1'b0;
    check("R7 buf_empty after write", buf_empty, 1'b0);
    @(negedge clk);
    check("R3 start bit low", txd, 1'b0);
    check("R7 buf_empty after transfer", buf_empty, 1'b1);
    wait_idle();

    // 9 data, even parity, two stops, back-to-back, irq on transfer
    clear_irq();
    data_nine = 1'b1; par_en = 1'b1; par_odd = 1'b0; stop_two = 1'b1; irq_sel = 1'b0;
    write(9'h1C3);
    write(9'h0F0);
    check("R6 second word buffered", buf_empty, 1'b0);
    wait_idle();
    check("R12 irq after transfer", irq_req, 1'b1);
    clear_irq();
    check("R13 irq cleared", irq_req, 1'b0);

    // sparse count source, n=1, odd parity, irq on completion
    src_mode = 1; div_n = 8'd1;
    data_nine = 1'b0; par_odd = 1'b1; stop_two = 1'b0; irq_sel = 1'b1;
    write(9'h137);
    step(40);
    check("R12 no irq mid frame", irq_req, 1'b0);
    wait_idle();
    check("R12 irq on completion", irq_req, 1'b1);
    step(5);
    check("R13 irq held", irq_req, 1'b1);
    clear_irq();
    src_mode = 0; div_n = 8'd0; par_en = 1'b0;

    // CTS gating
    cts_en = 1'b1; cts_n = 1'b1;
    write(9'h05A);
    step(50);
    check("R9 held by cts txd", txd, 1'b1);
    check("R9 held by cts tx_empty", tx_empty, 1'b0);
    @(negedge clk); cts_n = 1'b0;
    @(negedge clk);
    check("R10 start after cts low", txd, 1'b0);
    write(9'h0C3);
    step(20);
    cts_n = 1'b1;
    step(400);
    check("R9 stopped after frame txd", txd, 1'b1);
    check("R9 word kept", buf_empty, 1'b0);
    cts_n = 1'b0;
    wait_idle();
    cts_en = 1'b0;

    // transmit enable cleared during a frame
    write(9'h011);
    step(10);
    write(9'h0EE);
    tx_en = 1'b0;
    step(400);
    check("R11 line idle when disabled", txd, 1'b1);
    check("R11 word retained", buf_empty, 1'b0);
    tx_en = 1'b1;
    wait_idle();
    check("R8 idle at end", tx_empty, 1'b1);

    done = 1'b1;
    step(1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule